// File: doc/BRIEF.md
# CAN Bus Dominant-Level Wake Detector

This block sits beside a CAN transceiver and watches its receive line while the node sleeps. It does not decode frames. It measures how long the bus stays dominant, counting cycles of a free-running system clock. When one unbroken dominant interval lasts longer than a programmable minimum time, the block wakes. The default minimum is 5 µs, which is about two and a half bit times at 500 kbit/s. Any dominant interval that is long enough causes a wake, whatever produced it. A six-bit active error flag, which lasts 12 µs at that rate, wakes the node in the same way as the start of a valid frame.

On a wake the block raises its inhibit/enable output so that the supply and transceiver can power up. It also raises a wake flag and gives a one-cycle wake event to the host. It then stays in an awake-unconfirmed state. The host decodes the traffic and decides whether the wake reason is valid. It either confirms the wake or commands the block back to sleep. The receive input first passes through a multi-stage synchronizer. A glitch filter then removes level excursions shorter than a few clock cycles. Only after that is the dominant time counted.

Top module: `canwk_detector`

## Requirements
- R1: After reset the block is asleep: `inhibit_o` = 0, `wake_o` = 0 and `wake_evt_o` = 0.
- R2: The dominant level is `rx_i` = 0. While asleep, the block wakes when the filtered line has been dominant for WAKE_CYC consecutive clock cycles, where WAKE_CYC = floor(CLK_FREQ_HZ × WAKE_NS / 10^9) + 1. With the defaults (20 MHz, 5000 ns) WAKE_CYC = 101: a dominant pulse of 100 cycles does not wake the block and a pulse of 101 cycles does.
- R3: A recessive interval (`rx_i` = 1) of FILT_LEN or more cycles (default 3) restarts the dominant count from zero. Two dominant pieces that are separated by such a gap are never added together.
- R4: A level excursion shorter than FILT_LEN cycles is ignored. A recessive glitch inside a dominant interval does not break the count, and the glitch cycles count as dominant. A dominant pulse shorter than FILT_LEN cycles is never counted.
- R5: Frame content has no effect. Any dominant interval of WAKE_CYC cycles or more wakes the block, including a six-bit active error flag of 240 cycles at the defaults.
- R6: On a wake, `inhibit_o` and `wake_o` both go to 1, and `wake_evt_o` is 1 for exactly one cycle.
- R7: When `confirm_cmd_i` = 1 in the awake-unconfirmed state, the block moves to the confirmed awake state: `wake_o` goes to 0 and `inhibit_o` stays at 1.
- R8: When `sleep_cmd_i` = 1 in either awake state, the block returns to sleep on the next clock: `inhibit_o` = 0 and `wake_o` = 0. If `sleep_cmd_i` and `confirm_cmd_i` are both 1 in the same cycle, the sleep command wins.
- R9: While the block is awake, dominant activity produces no further `wake_evt_o` pulse and does not re-raise `wake_o`. After a return to sleep, a new and complete WAKE_CYC interval is needed, even if the bus was already dominant when the sleep command arrived.
- R10: While the block is asleep, `confirm_cmd_i` and `sleep_cmd_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Transceiver receive line; 0 = dominant, 1 = recessive |
| sleep_cmd_i | input | 1 | Host command: enter sleep |
| confirm_cmd_i | input | 1 | Host command: wake reason is valid |
| inhibit_o | output | 1 | Enable/inhibit output; 1 while awake |
| wake_o | output | 1 | Wake flag; 1 while the wake waits for the host's decision |
| wake_evt_o | output | 1 | One-cycle pulse when a wake is recognised |

## Verification
The bench probes both sides of the threshold with pulses of 100 and 101 cycles. An off-by-one comparator would wake on the first pulse or miss the second. It splits dominant runs with recessive gaps that are just below and just at the filter length. A counter that did not clear would add the pieces together and wake too early, and a filter that was too weak would clear the count on a glitch and miss a valid wake. It keeps the bus dominant across a sleep command and while the block is awake. A counter that kept its value would re-wake at once, and a detector that stayed armed would pulse the wake event a second time. It also issues sleep and confirm together, and sends commands while asleep, to expose wrong command priority and commands that leak into the sleep state.

// File: rtl/canwk_pkg.sv
package canwk_pkg;

   typedef enum logic [1:0] {
      ST_SLEEP  = 2'd0,
      ST_UNCONF = 2'd1,
      ST_AWAKE  = 2'd2
   } canwk_state_e;

   // Cycle count of the wake threshold: the time in clock cycles, plus one,
   // so that the dominant time must strictly exceed the threshold time.
   function automatic int unsigned wake_cycles(input longint unsigned clk_hz,
                                                input longint unsigned thr_ns);
      longint unsigned prod;
      prod = (clk_hz * thr_ns) / 64'd1_000_000_000;
      return int'(prod) + 1;
   endfunction

endpackage

// File: rtl/canwk_sync.sv
module canwk_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("canwk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= RESET_VAL;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[i] <= RESET_VAL;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/canwk_glitch.sv
module canwk_glitch #(
   parameter int unsigned FILT_LEN  = 3,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic filt_o
);

   if (FILT_LEN < 1) begin : g_bad_len
      $error("canwk_glitch: FILT_LEN must be at least 1");
   end

   localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   logic filt_q;

   if (FILT_LEN == 1) begin : g_direct
      // One cycle of agreement is enough: plain register stage.
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) filt_q <= RESET_VAL;
         else         filt_q <= raw_i;
      end
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
      logic [CW-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            filt_q <= RESET_VAL;
            run_q  <= '0;
         end else if (raw_i != filt_q) begin
            if (run_q == LAST) begin
               filt_q <= raw_i;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end

      // R4: the filtered level only ever moves toward the raw level.
      p_filt_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !$stable(filt_q) |-> (filt_q == $past(raw_i)));

      // R4: an input that agrees with the output keeps the output steady.
      p_filt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (raw_i == filt_q) |=> $stable(filt_q));
   end

   assign filt_o = filt_q;

endmodule

// File: rtl/canwk_dom_timer.sv
module canwk_dom_timer #(
   parameter int unsigned WAKE_CYC = 101
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic dom_i,
   output logic hit_o
);

   if (WAKE_CYC < 2) begin : g_bad_thr
      $error("canwk_dom_timer: WAKE_CYC must be at least 2");
   end

   localparam int unsigned CW = $clog2(WAKE_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);
   localparam logic [CW-1:0] TOP  = CW'(WAKE_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (arm_i && dom_i) begin
         if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   assign hit_o = arm_i && dom_i && (cnt_q == LAST);

   // R2: the count never runs past the threshold.
   p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= TOP);

   // R3: a recessive sample leaves a zero count behind it.
   p_recessive_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dom_i |=> (cnt_q == '0));

   // R9: a disarmed timer restarts from zero.
   p_disarm_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !arm_i |=> (cnt_q == '0));

endmodule

// File: rtl/canwk_fsm.sv
module canwk_fsm
   import canwk_pkg::*;
(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         hit_i,
   input  logic         sleep_cmd_i,
   input  logic         confirm_cmd_i,
   output logic         arm_o,
   output logic         inhibit_o,
   output logic         wake_o,
   output logic         wake_evt_o
);

   canwk_state_e state_q, state_d;
   logic         evt_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_SLEEP:  if (hit_i) state_d = ST_UNCONF;
         ST_UNCONF: begin
            if (sleep_cmd_i)        state_d = ST_SLEEP;
            else if (confirm_cmd_i) state_d = ST_AWAKE;
         end
         ST_AWAKE:  if (sleep_cmd_i) state_d = ST_SLEEP;
         default:   state_d = ST_SLEEP;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_SLEEP;
         evt_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         evt_q   <= (state_q == ST_SLEEP) && hit_i;
      end
   end

   assign arm_o      = (state_q == ST_SLEEP);
   assign inhibit_o  = (state_q != ST_SLEEP);
   assign wake_o     = (state_q == ST_UNCONF);
   assign wake_evt_o = evt_q;

   // R6: a wake event coincides with the wake flag.
   p_evt_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q |-> (wake_o && inhibit_o));

   // R6: the event lasts a single cycle.
   p_evt_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q |=> !evt_q);

   // R7: a confirm without sleep moves to the confirmed state.
   p_confirm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_UNCONF && confirm_cmd_i && !sleep_cmd_i) |=> (state_q == ST_AWAKE));

   // R8: sleep from any awake state lands in sleep next cycle.
   p_sleep_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_SLEEP && sleep_cmd_i) |=> (state_q == ST_SLEEP));

   // R9: no wake event follows a cycle spent awake.
   p_no_rewake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_SLEEP) |=> !evt_q);

   // R10: only the timer leaves sleep; commands do not.
   p_sleep_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_SLEEP && !hit_i) |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/canwk_detector.sv
module canwk_detector #(
   parameter longint unsigned CLK_FREQ_HZ = 20_000_000,
   parameter longint unsigned WAKE_NS     = 5000,
   parameter int unsigned     SYNC_STAGES = 2,
   parameter int unsigned     FILT_LEN    = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_i,
   input  logic sleep_cmd_i,
   input  logic confirm_cmd_i,
   output logic inhibit_o,
   output logic wake_o,
   output logic wake_evt_o
);

   localparam int unsigned WAKE_CYC = canwk_pkg::wake_cycles(CLK_FREQ_HZ, WAKE_NS);

   if (WAKE_CYC <= FILT_LEN) begin : g_bad_ratio
      $error("canwk_detector: threshold must be longer than the glitch filter");
   end

   logic rx_sync;
   logic rx_filt;
   logic arm;
   logic hit;

   canwk_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (rx_i),
      .q_o    (rx_sync)
   );

   canwk_glitch #(
      .FILT_LEN  (FILT_LEN),
      .RESET_VAL (1'b1)
   ) u_glitch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (rx_sync),
      .filt_o (rx_filt)
   );

   canwk_dom_timer #(
      .WAKE_CYC (WAKE_CYC)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm),
      .dom_i  (!rx_filt),
      .hit_o  (hit)
   );

   canwk_fsm u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .hit_i         (hit),
      .sleep_cmd_i   (sleep_cmd_i),
      .confirm_cmd_i (confirm_cmd_i),
      .arm_o         (arm),
      .inhibit_o     (inhibit_o),
      .wake_o        (wake_o),
      .wake_evt_o    (wake_evt_o)
   );

   // R1: nothing is awake while reset is held.
   p_reset_quiet_r1: assert property (@(posedge clk_i)
      !rst_ni |-> (!inhibit_o && !wake_o && !wake_evt_o));

   // R5: a wake flag always goes with the enable output.
   p_flag_needs_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> inhibit_o);

endmodule

// File: tb/canwk_detector_tb.sv
module canwk_detector_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WAKE = 101;   // 20 MHz x 5 us = 100 cycles, strictly more
   localparam int FILT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic sleep_cmd = 1'b0;
   logic confirm_cmd = 1'b0;
   logic inhibit, wake, wake_evt;

   int checks = 0;
   int errors = 0;
   int evt_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   canwk_detector u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .rx_i          (rx),
      .sleep_cmd_i   (sleep_cmd),
      .confirm_cmd_i (confirm_cmd),
      .inhibit_o     (inhibit),
      .wake_o        (wake),
      .wake_evt_o    (wake_evt)
   );

   always @(negedge clk) if (rst_n && wake_evt) evt_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic level(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic cmd(input logic s, input logic c);
      sleep_cmd = s;
      confirm_cmd = c;
      @(negedge clk);
      sleep_cmd = 1'b0;
      confirm_cmd = 1'b0;
   endtask

   function automatic int exp_wake(input int len);
      return (len >= WAKE && len >= FILT) ? 1 : 0;
   endfunction

   task automatic go_sleep();
      if (inhibit) cmd(1'b1, 1'b0);
      @(negedge clk);
   endtask

   task automatic pulse_check(input string req, input int len);
      int e0;
      e0 = evt_cnt;
      level(1'b0, len);
      level(1'b1, 10);
      chk(req, wake, exp_wake(len));
      chk(req, evt_cnt - e0, exp_wake(len));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int seed;
      int e0;
      seed = $urandom(32'h0C0FFEE5);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 inhibit", inhibit, 0);
      chk("R1 wake", wake, 0);
      chk("R1 evt", wake_evt, 0);
      rst_n = 1'b1;
      level(1'b1, 5);

      // R2 threshold edges
      pulse_check("R2 len100", 100);
      go_sleep();
      pulse_check("R2 len101", 101);
      // R6 enable with flag
      chk("R6 inhibit", inhibit, 1);
      go_sleep();
      chk("R8 inhibit", inhibit, 0);

      // R5 active error flag: six bits of 40 cycles
      pulse_check("R5 errflag", 240);
      // R7 confirm
      cmd(1'b0, 1'b1);
      chk("R7 wake", wake, 0);
      chk("R7 inhibit", inhibit, 1);
      // R9 dominant while awake: no new event
      e0 = evt_cnt;
      level(1'b0, 300);
      level(1'b1, 10);
      chk("R9 evt", evt_cnt - e0, 0);
      chk("R9 wake", wake, 0);
      go_sleep();
      chk("R8 from awake", inhibit, 0);

      // R4 short recessive glitch is ignored
      level(1'b0, 60); level(1'b1, FILT - 1); level(1'b0, 60); level(1'b1, 10);
      chk("R4 glitch", wake, 1);
      // R8 sleep beats confirm
      cmd(1'b1, 1'b1);
      chk("R8 priority inhibit", inhibit, 0);
      chk("R8 priority wake", wake, 0);

      // R3 gap of FILT restarts the count
      level(1'b0, 60); level(1'b1, FILT); level(1'b0, 60); level(1'b1, 10);
      chk("R3 gap", wake, 0);
      // R4 short dominant pulses are never counted
      for (int i = 0; i < 40; i++) begin
         level(1'b0, FILT - 1); level(1'b1, 1);
      end
      level(1'b1, 10);
      chk("R4 short dom", wake, 0);

      // R10 commands while asleep
      cmd(1'b0, 1'b1);
      chk("R10 confirm", inhibit, 0);
      cmd(1'b1, 1'b0);
      chk("R10 sleep", inhibit, 0);

      // R9 sleep while bus stays dominant: fresh count needed
      level(1'b0, 120);
      chk("R9 first wake", wake, 1);
      sleep_cmd = 1'b1;
      @(negedge clk);
      sleep_cmd = 1'b0;
      repeat (50) @(negedge clk);
      chk("R9 no early rewake", inhibit, 0);
      repeat (100) @(negedge clk);
      chk("R9 rewake", wake, 1);
      level(1'b1, 10);
      go_sleep();

      // R2 random single pulses
      for (int t = 0; t < 40; t++) begin
         int len;
         len = 20 + int'($urandom_range(230));
         if (t % 5 == 0) len = WAKE - 1 + int'($urandom_range(2));
         pulse_check("R2 random", len);
         if (wake && $urandom_range(1) == 1) cmd(1'b0, 1'b1);
         go_sleep();
         chk("R8 random sleep", inhibit, 0);
      end

      // R3/R4 random bursts with gaps
      for (int t = 0; t < 30; t++) begin
         int run;
         int ew;
         run = 0;
         ew = 0;
         for (int s = 0; s < 5; s++) begin
            int d;
            int g;
            d = 10 + int'($urandom_range(50));
            g = 1 + int'($urandom_range(5));
            run += d;
            if (run >= WAKE) ew = 1;
            level(1'b0, d);
            level(1'b1, g);
            if (g < FILT) run += g; else run = 0;
         end
         level(1'b1, 10);
         chk("R3 R4 burst", wake, ew);
         go_sleep();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule